// File: doc/BRIEF.md
# Variable Page Size Translation Buffer

This block is a small, fully associative address translation buffer. Every entry maps one page whose size is chosen per entry, from 4 KiB up to 256 MiB in steps of four. Entries are tagged with an 8-bit translation ID and an address-space bit, and they carry memory attributes and six permission bits. Software never writes an entry directly. It first fills four 32-bit staging registers. Register 0 chooses the entry, and registers 1 to 3 hold the compare fields, the attributes and the permissions. A write strobe then commits the staged value. A read strobe copies an entry back into staging registers 1 to 3, where its contents can be inspected.

The lookup port takes an effective address, a process ID, an address-space bit, a privilege bit and an access type. One cycle later it returns hit or miss, the physical address, the attributes and a permission fault. A flash-invalidate input clears every entry that is not protected.

Top module: `vps_tlb`

## Requirements
- R1: After reset, every entry is invalid. All four staging registers and all lookup outputs read zero.
- R2: When `stg_we` is high, `stg_wdata` is written into the staging register chosen by `stg_sel` (0 to 3). The new value appears on the matching `stgN_q` output in the next cycle.
- R3: On `ent_wr`, the staged value is committed only when staging register 0 bit 28 is 1. The target is the entry named by staging register 0 bits 19:16. The fields written are: register 1 valid[31], protect[30], ID[23:16], space[12], size[11:8]; register 2 page[31:12], shared[9], impl[6:5], write-through/inhibit/coherent/guarded/endian[4:0]; register 3 real page[31:12], user[9:6], permissions[5:0]. With bit 28 at 0, no entry changes.
- R4: On `ent_rd`, when staging register 0 bit 28 is 1, registers 1 to 3 are loaded from the selected entry in the R3 layout, with all other bits zero. Register 0 keeps its value. This load takes precedence over a same-cycle `stg_we` to registers 1 to 3.
- R5: An entry matches only when all of these hold:
  - it is valid;
  - its space bit equals `lk_as`;
  - its ID equals `lk_pid`, or its ID is zero (zero matches any process).
- R6: For a size code n from 1 to 9, the low 2(n-1) bits of the page number are left out of the compare. The physical address is formed from three parts:
  - those low bits, taken from the effective address;
  - the remaining page bits, taken from the real page number;
  - the low 12 address bits, passed through unchanged.
- R7: An entry whose size code is 0 or 10 to 15 never matches.
- R8: When several entries match, the lowest-numbered entry supplies the result.
- R9: On a hit, `lk_fault` is 1 when the selected permission bit is clear. The bit index is 2·k + (user ? 1 : 0), where k is 0 for read (`lk_acc`=00), 1 for write (01) and 2 for execute (1x). Bit 0 is supervisor read and bit 5 is user execute.
- R10: A lookup with no match sets `lk_miss` and clears `lk_hit`. On a miss, `lk_pa`, `lk_attr` and `lk_fault` are all zero.
- R11: `flash_inv` clears the valid bit of every entry whose protect bit is 0. Protected entries stay valid. If a committed write targets an entry in the same cycle, the write wins for that entry.
- R12: Lookup results appear in the cycle after `lk_req`. In a cycle with no request, all lookup outputs are zero.
- R13: `lk_attr` is {shared, impl[6], impl[5], write-through, inhibit, coherent, guarded, endian} of the entry that hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_we | input | 1 | Staging register write enable |
| stg_sel | input | 2 | Staging register index |
| stg_wdata | input | 32 | Staging write data |
| ent_wr | input | 1 | Commit staging into the selected entry |
| ent_rd | input | 1 | Copy the selected entry into staging |
| flash_inv | input | 1 | Invalidate all unprotected entries |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_pid | input | 8 | Process ID |
| lk_as | input | 1 | Address-space bit |
| lk_sup | input | 1 | 1 = supervisor access, 0 = user access |
| lk_acc | input | 2 | Access type: 00 read, 01 write, 1x execute |
| stg0_q | output | 32 | Staging register 0 |
| stg1_q | output | 32 | Staging register 1 |
| stg2_q | output | 32 | Staging register 2 |
| stg3_q | output | 32 | Staging register 3 |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss |
| lk_pa | output | 32 | Physical address |
| lk_attr | output | 8 | Page attributes |
| lk_fault | output | 1 | Permission fault |

## Verification
The assertions expect the control inputs to be known, 0 or 1, in every cycle after reset. They also take a commit, a flash and a read in the same cycle as legal combinations, with the precedence set by R4 and R11. The checks that protected entries survive flash allow for a same-cycle commit to that entry, because the commit may legally clear it. The stimulus always drives every control input on the falling edge with defined values. Its random phase deliberately combines strobes in the same cycle, so the precedence rules are exercised rather than avoided.

// File: rtl/vps_pkg.sv
package vps_pkg;
    localparam int PN_W     = 20;
    localparam int OFS_W    = 12;
    localparam int TID_W    = 8;
    localparam int SZ_W     = 4;
    localparam int ATTR_W   = 8;
    localparam int USR_W    = 4;
    localparam int PERM_W   = 6;
    localparam int ESEL_W   = 4;
    localparam int ESEL_LSB = 16;
    localparam int TSEL_BIT = 28;
    localparam int SZ_MAX   = 9;

    typedef struct packed {
        logic              v;
        logic              ip;
        logic [TID_W-1:0]  tid;
        logic              ts;
        logic [SZ_W-1:0]   sz;
        logic [PN_W-1:0]   epn;
        logic [ATTR_W-1:0] attr;
        logic [PN_W-1:0]   rpn;
        logic [USR_W-1:0]  usr;
        logic [PERM_W-1:0] perm;
    } vps_entry_t;

    function automatic vps_entry_t unpack_entry(input logic [31:0] r1,
                                                input logic [31:0] r2,
                                                input logic [31:0] r3);
        vps_entry_t e;
        e.v    = r1[31];
        e.ip   = r1[30];
        e.tid  = r1[23:16];
        e.ts   = r1[12];
        e.sz   = r1[11:8];
        e.epn  = r2[31:12];
        e.attr = {r2[9], r2[6:0]};
        e.rpn  = r3[31:12];
        e.usr  = r3[9:6];
        e.perm = r3[5:0];
        return e;
    endfunction

    function automatic logic [31:0] pack_r1(input vps_entry_t e);
        return {e.v, e.ip, 6'b0, e.tid, 3'b0, e.ts, e.sz, 8'b0};
    endfunction

    function automatic logic [31:0] pack_r2(input vps_entry_t e);
        return {e.epn, 2'b0, e.attr[7], 2'b0, e.attr[6:0]};
    endfunction

    function automatic logic [31:0] pack_r3(input vps_entry_t e);
        return {e.rpn, 2'b0, e.usr, e.perm};
    endfunction

    // permission bit index: read 0/1, write 2/3, execute 4/5; odd = user
    function automatic logic [2:0] perm_index(input logic [1:0] acc, input logic sup);
        logic [1:0] k;
        k = acc[1] ? 2'd2 : {1'b0, acc[0]};
        return {k, ~sup};
    endfunction
endpackage

// File: rtl/vps_match.sv
module vps_match
    import vps_pkg::*;
(
    input  logic              ent_v,
    input  logic              ent_ts,
    input  logic [TID_W-1:0]  ent_tid,
    input  logic [SZ_W-1:0]   ent_sz,
    input  logic [PN_W-1:0]   ent_epn,
    input  logic [PN_W-1:0]   vpn,
    input  logic [TID_W-1:0]  pid,
    input  logic              as_i,
    output logic              hit,
    output logic [PN_W-1:0]   mask
);
    logic       sz_ok;
    logic [4:0] shamt;
    logic       tid_ok;

    always_comb begin
        sz_ok  = (ent_sz != '0) && (ent_sz <= SZ_W'(SZ_MAX));
        shamt  = {ent_sz - SZ_W'(1), 1'b0};
        mask   = sz_ok ? ((PN_W'(1) << shamt) - PN_W'(1)) : '0;
        tid_ok = (ent_tid == '0) || (ent_tid == pid);
        hit    = ent_v && sz_ok && (ent_ts == as_i) && tid_ok &&
                 (((vpn ^ ent_epn) & ~mask) == '0);
    end
endmodule

// File: rtl/vps_prio.sv
module vps_prio #(
    parameter int N     = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any,
    output logic [N-1:0]     gnt
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
        gnt = any ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/vps_tlb.sv
module vps_tlb
    import vps_pkg::*;
#(
    parameter int NUM_ENT = 16,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stg_we,
    input  logic [1:0]          stg_sel,
    input  logic [31:0]         stg_wdata,
    input  logic                ent_wr,
    input  logic                ent_rd,
    input  logic                flash_inv,
    input  logic                lk_req,
    input  logic [31:0]         lk_ea,
    input  logic [TID_W-1:0]    lk_pid,
    input  logic                lk_as,
    input  logic                lk_sup,
    input  logic [1:0]          lk_acc,
    output logic [31:0]         stg0_q,
    output logic [31:0]         stg1_q,
    output logic [31:0]         stg2_q,
    output logic [31:0]         stg3_q,
    output logic                lk_hit,
    output logic                lk_miss,
    output logic [31:0]         lk_pa,
    output logic [ATTR_W-1:0]   lk_attr,
    output logic                lk_fault
);
    typedef struct packed {
        vps_entry_t [NUM_ENT-1:0] ent;
        logic [3:0][31:0]         stg;
        logic                     hit;
        logic                     miss;
        logic                     fault;
        logic [31:0]              pa;
        logic [ATTR_W-1:0]        attr;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_ENT-1:0] hitv;
    logic [NUM_ENT-1:0] gnt;
    logic [NUM_ENT-1:0] wr_vec;
    logic [PN_W-1:0]    mask_a [NUM_ENT];
    logic [IDX_W-1:0]   gidx;
    logic               hit_any;
    logic               tsel;
    logic [ESEL_W-1:0]  esel;
    logic               sel_ok;
    logic [IDX_W-1:0]   eidx;

    assign tsel   = s_q.stg[0][TSEL_BIT];
    assign esel   = s_q.stg[0][ESEL_LSB +: ESEL_W];
    assign sel_ok = {1'b0, esel} < (ESEL_W+1)'(NUM_ENT);
    assign eidx   = esel[IDX_W-1:0];

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        vps_match u_match (
            .ent_v   (s_q.ent[g].v),
            .ent_ts  (s_q.ent[g].ts),
            .ent_tid (s_q.ent[g].tid),
            .ent_sz  (s_q.ent[g].sz),
            .ent_epn (s_q.ent[g].epn),
            .vpn     (lk_ea[31:OFS_W]),
            .pid     (lk_pid),
            .as_i    (lk_as),
            .hit     (hitv[g]),
            .mask    (mask_a[g])
        );
        assign wr_vec[g] = ent_wr && tsel && sel_ok && (eidx == IDX_W'(g));

        // protected entries survive flash unless rewritten
        assert_iprot_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (flash_inv && s_q.ent[g].v && s_q.ent[g].ip && !wr_vec[g]) |=> s_q.ent[g].v);
        assert_flash_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (flash_inv && !s_q.ent[g].ip && !wr_vec[g]) |=> !s_q.ent[g].v);
    end

    vps_prio #(.N(NUM_ENT)) u_prio (
        .req (hitv),
        .idx (gidx),
        .any (hit_any),
        .gnt (gnt)
    );

    vps_entry_t       sel_e;
    vps_entry_t       rd_e;
    logic [PN_W-1:0]  sel_m;
    logic [PN_W-1:0]  pa_pn;
    logic             perm_ok;

    always_comb begin
        sel_e   = s_q.ent[gidx];
        sel_m   = mask_a[gidx];
        rd_e    = s_q.ent[eidx];
        pa_pn   = (sel_e.rpn & ~sel_m) | (lk_ea[31:OFS_W] & sel_m);
        perm_ok = sel_e.perm[perm_index(lk_acc, lk_sup)];

        s_d = s_q;

        // lookup result, registered
        s_d.hit   = lk_req && hit_any;
        s_d.miss  = lk_req && !hit_any;
        s_d.pa    = (lk_req && hit_any) ? {pa_pn, lk_ea[OFS_W-1:0]} : '0;
        s_d.attr  = (lk_req && hit_any) ? sel_e.attr : '0;
        s_d.fault = lk_req && hit_any && !perm_ok;

        // staging registers
        if (stg_we) s_d.stg[stg_sel] = stg_wdata;
        if (ent_rd && tsel && sel_ok) begin
            s_d.stg[1] = pack_r1(rd_e);
            s_d.stg[2] = pack_r2(rd_e);
            s_d.stg[3] = pack_r3(rd_e);
        end

        // flash invalidate, then committed write
        for (int i = 0; i < NUM_ENT; i++) begin
            if (flash_inv && !s_q.ent[i].ip) s_d.ent[i].v = 1'b0;
            if (wr_vec[i]) s_d.ent[i] = unpack_entry(s_q.stg[1], s_q.stg[2], s_q.stg[3]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stg0_q   = s_q.stg[0];
    assign stg1_q   = s_q.stg[1];
    assign stg2_q   = s_q.stg[2];
    assign stg3_q   = s_q.stg[3];
    assign lk_hit   = s_q.hit;
    assign lk_miss  = s_q.miss;
    assign lk_pa    = s_q.pa;
    assign lk_attr  = s_q.attr;
    assign lk_fault = s_q.fault;

    assert_hit_miss_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));
    assert_miss_no_xlate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_pa == '0 && lk_attr == '0 && !lk_fault));
    assert_resp_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit || lk_miss) |-> $past(lk_req));
    assert_req_gets_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (lk_hit || lk_miss));
    assert_fault_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);
    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & hitv) == gnt));
endmodule

// File: tb/tb_vps_tlb.sv
`timescale 1ns/1ps
module tb_vps_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stg_we = 0, ent_wr = 0, ent_rd = 0, flash_inv = 0, lk_req = 0;
    logic [1:0]  stg_sel = 0, lk_acc = 0;
    logic [31:0] stg_wdata = 0, lk_ea = 0;
    logic [7:0]  lk_pid = 0;
    logic        lk_as = 0, lk_sup = 0;
    logic [31:0] stg0_q, stg1_q, stg2_q, stg3_q, lk_pa;
    logic        lk_hit, lk_miss, lk_fault;
    logic [7:0]  lk_attr;

    always #2.5 clk = ~clk;

    vps_tlb dut (.*);

    int checks = 0, fails = 0;

    // reference model state
    logic [31:0] m_s [4];
    bit          m_v [16], m_ip [16], m_ts [16];
    logic [7:0]  m_tid [16], m_attr [16];
    logic [3:0]  m_sz [16], m_usr [16];
    logic [19:0] m_epn [16], m_rpn [16];
    logic [5:0]  m_perm [16];
    logic        e_hit = 0, e_miss = 0, e_fault = 0;
    logic [31:0] e_pa = 0;
    logic [7:0]  e_attr = 0;

    function automatic logic [31:0] mk0(bit t, logic [3:0] idx);
        return {3'b0, t, 8'b0, idx, 16'b0};
    endfunction
    function automatic logic [31:0] mk1(bit v, bit ip, logic [7:0] tid, bit ts, logic [3:0] sz);
        return {v, ip, 6'b0, tid, 3'b0, ts, sz, 8'b0};
    endfunction
    function automatic logic [31:0] mk2(logic [19:0] epn, logic [7:0] a);
        return {epn, 2'b0, a[7], 2'b0, a[6:0]};
    endfunction
    function automatic logic [31:0] mk3(logic [19:0] rpn, logic [3:0] u, logic [5:0] p);
        return {rpn, 2'b0, u, p};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_eval();
        logic [31:0] os [4];
        int          found, ign, pi;
        logic [19:0] vpn, msk;
        bit          t;
        logic [3:0]  ix;
        e_hit = 0; e_miss = 0; e_pa = 0; e_attr = 0; e_fault = 0;
        if (lk_req) begin
            vpn = lk_ea[31:12];
            found = -1;
            for (int i = 0; i < 16; i++) begin
                if (found < 0 && m_v[i] && m_sz[i] >= 1 && m_sz[i] <= 9 &&
                    m_ts[i] == lk_as && (m_tid[i] == 0 || m_tid[i] == lk_pid)) begin
                    ign = 2 * (m_sz[i] - 1);
                    if ((vpn >> ign) == (m_epn[i] >> ign)) found = i;
                end
            end
            if (found >= 0) begin
                ign = 2 * (m_sz[found] - 1);
                msk = 20'((1 << ign) - 1);
                e_hit  = 1;
                e_pa   = {(m_rpn[found] & ~msk) | (vpn & msk), lk_ea[11:0]};
                e_attr = m_attr[found];
                pi = (lk_acc >= 2) ? 4 : (lk_acc == 1 ? 2 : 0);
                pi = pi + (lk_sup ? 0 : 1);
                e_fault = !m_perm[found][pi];
            end else e_miss = 1;
        end
        for (int i = 0; i < 4; i++) os[i] = m_s[i];
        t  = os[0][28];
        ix = os[0][19:16];
        if (stg_we) m_s[stg_sel] = stg_wdata;
        if (ent_rd && t) begin
            m_s[1] = mk1(m_v[ix], m_ip[ix], m_tid[ix], m_ts[ix], m_sz[ix]);
            m_s[2] = mk2(m_epn[ix], m_attr[ix]);
            m_s[3] = mk3(m_rpn[ix], m_usr[ix], m_perm[ix]);
        end
        if (flash_inv)
            for (int i = 0; i < 16; i++) if (!m_ip[i]) m_v[i] = 0;
        if (ent_wr && t) begin
            m_v[ix] = os[1][31]; m_ip[ix] = os[1][30]; m_tid[ix] = os[1][23:16];
            m_ts[ix] = os[1][12]; m_sz[ix] = os[1][11:8];
            m_epn[ix] = os[2][31:12]; m_attr[ix] = {os[2][9], os[2][6:0]};
            m_rpn[ix] = os[3][31:12]; m_usr[ix] = os[3][9:6]; m_perm[ix] = os[3][5:0];
        end
    endtask

    // one clock: model update, edge, then compare on the falling edge
    task automatic step();
        model_eval();
        @(posedge clk);
        @(negedge clk);
        chk("R2/R4 stg0", stg0_q, m_s[0]);
        chk("R2/R4 stg1", stg1_q, m_s[1]);
        chk("R2/R4 stg2", stg2_q, m_s[2]);
        chk("R2/R4 stg3", stg3_q, m_s[3]);
        chk("R5 hit", 32'(lk_hit), 32'(e_hit));
        chk("R10 miss", 32'(lk_miss), 32'(e_miss));
        chk("R6 pa", lk_pa, e_pa);
        chk("R13 attr", 32'(lk_attr), 32'(e_attr));
        chk("R9 fault", 32'(lk_fault), 32'(e_fault));
    endtask

    task automatic set_stg(logic [1:0] s, logic [31:0] d);
        stg_we = 1; stg_sel = s; stg_wdata = d; step(); stg_we = 0;
    endtask
    task automatic load(logic [3:0] idx, bit t, logic [31:0] r1, logic [31:0] r2, logic [31:0] r3);
        set_stg(0, mk0(t, idx)); set_stg(1, r1); set_stg(2, r2); set_stg(3, r3);
        ent_wr = 1; step(); ent_wr = 0;
    endtask
    task automatic look(logic [31:0] ea, logic [7:0] pid, bit as, bit sup, logic [1:0] acc);
        lk_req = 1; lk_ea = ea; lk_pid = pid; lk_as = as; lk_sup = sup; lk_acc = acc;
        step(); lk_req = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_s[i] = 0;
        for (int i = 0; i < 16; i++) begin
            m_v[i] = 0; m_ip[i] = 0; m_ts[i] = 0; m_tid[i] = 0; m_attr[i] = 0;
            m_sz[i] = 0; m_usr[i] = 0; m_epn[i] = 0; m_rpn[i] = 0; m_perm[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 stg0", stg0_q, 0); chk("R1 stg1", stg1_q, 0);
        chk("R1 hit", 32'(lk_hit), 0); chk("R1 miss", 32'(lk_miss), 0);
        look(32'h1234_5678, 8'd5, 0, 1, 2'b00);
        chk("R1 empty miss", 32'(lk_miss), 1);
        // R2: staging write
        set_stg(1, 32'hDEAD_BEEF);
        chk("R2 stg1 write", stg1_q, 32'hDEAD_BEEF);
        // entry 3: 4K, tid 5, perm ur|sr, attr 0xAB
        load(3, 1, mk1(1, 0, 8'd5, 0, 4'd1), mk2(20'h12345, 8'hAB), mk3(20'hABCDE, 4'h0, 6'h03));
        look(32'h1234_5678, 8'd5, 0, 1, 2'b00);
        chk("R6 4K pa", lk_pa, 32'hABCD_E678);
        chk("R13 attr", 32'(lk_attr), 32'hAB);
        chk("R9 sup read ok", 32'(lk_fault), 0);
        look(32'h1234_5678, 8'd5, 0, 0, 2'b00);
        chk("R9 user read ok", 32'(lk_fault), 0);
        look(32'h1234_5678, 8'd5, 0, 0, 2'b01);
        chk("R9 user write fault", 32'(lk_fault), 1);
        chk("R9 fault still hits", 32'(lk_hit), 1);
        look(32'h1234_5678, 8'd6, 0, 1, 2'b00);
        chk("R5 pid mismatch", 32'(lk_miss), 1);
        chk("R10 miss pa zero", lk_pa, 0);
        look(32'h1234_5678, 8'd5, 1, 1, 2'b00);
        chk("R5 space mismatch", 32'(lk_miss), 1);
        // entry 7: 1M, global id
        load(7, 1, mk1(1, 0, 8'd0, 0, 4'd5), mk2(20'h40000, 8'h00), mk3(20'h80000, 4'h0, 6'h3F));
        look(32'h400A_B123, 8'd9, 0, 0, 2'b10);
        chk("R6 1M pa", lk_pa, 32'h800A_B123);
        chk("R5 global id hit", 32'(lk_hit), 1);
        // entry 2: 256M, protected, overlaps entry 7
        load(2, 1, mk1(1, 1, 8'd0, 0, 4'd9), mk2(20'h40000, 8'h00), mk3(20'h10000, 4'hA, 6'h3F));
        look(32'h400A_B123, 8'd9, 0, 0, 2'b10);
        chk("R8 lowest wins", lk_pa, 32'h100A_B123);
        // R7: undefined size codes
        load(9, 1, mk1(1, 0, 8'd0, 0, 4'd0), mk2(20'h55555, 8'h00), mk3(20'h1, 4'h0, 6'h3F));
        load(10, 1, mk1(1, 0, 8'd0, 0, 4'd12), mk2(20'h66666, 8'h00), mk3(20'h1, 4'h0, 6'h3F));
        look(32'h5555_5000, 8'd0, 0, 1, 2'b00);
        chk("R7 size 0 no match", 32'(lk_miss), 1);
        look(32'h6666_6000, 8'd0, 0, 1, 2'b00);
        chk("R7 size 12 no match", 32'(lk_miss), 1);
        // R3: table-select clear ignores the commit
        load(11, 0, mk1(1, 0, 8'd0, 0, 4'd1), mk2(20'h77777, 8'h00), mk3(20'h1, 4'h0, 6'h3F));
        look(32'h7777_7000, 8'd0, 0, 1, 2'b00);
        chk("R3 tsel0 ignored", 32'(lk_miss), 1);
        // R4: read back entry 2
        set_stg(0, mk0(1, 2));
        ent_rd = 1; step(); ent_rd = 0;
        chk("R4 rd r1", stg1_q, 32'hC000_0900);
        chk("R4 rd r2", stg2_q, 32'h4000_0000);
        chk("R4 rd r3", stg3_q, 32'h1000_02BF);
        chk("R4 r0 kept", stg0_q, mk0(1, 2));
        // R11: flash
        flash_inv = 1; step(); flash_inv = 0;
        look(32'h400A_B123, 8'd9, 0, 1, 2'b00);
        chk("R11 protected kept", lk_pa, 32'h100A_B123);
        look(32'h1234_5678, 8'd5, 0, 1, 2'b00);
        chk("R11 unprotected cleared", 32'(lk_miss), 1);
        // R12: idle cycle
        step();
        chk("R12 idle hit", 32'(lk_hit), 0);
        chk("R12 idle miss", 32'(lk_miss), 0);
        // random phase, strobes combined freely
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 100;
            lk_req = ($urandom % 2) == 1;
            lk_ea  = 32'h4000_0000 | ($urandom & 32'h00FF_FFFF);
            if (($urandom % 4) == 0) lk_ea = $urandom;
            lk_pid = 8'($urandom % 4); lk_as = 1'($urandom % 2);
            lk_sup = 1'($urandom % 2); lk_acc = 2'($urandom % 4);
            stg_we = r < 35; stg_sel = 2'($urandom % 4);
            case (stg_sel)
                2'd0: stg_wdata = mk0(($urandom % 4) != 0, 4'($urandom));
                2'd1: stg_wdata = (($urandom % 5) == 0) ? $urandom :
                      mk1(1'($urandom), 1'($urandom), 8'($urandom % 4), 1'($urandom), 4'($urandom % 12));
                2'd2: stg_wdata = (($urandom % 5) == 0) ? $urandom :
                      mk2(20'h40000 | 20'($urandom % 4096), 8'($urandom));
                default: stg_wdata = $urandom;
            endcase
            ent_wr = ($urandom % 5) == 0;
            ent_rd = ($urandom % 6) == 0;
            flash_inv = ($urandom % 40) == 0;
            step();
            stg_we = 0; ent_wr = 0; ent_rd = 0; flash_inv = 0; lk_req = 0;
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule